// File: doc/BRIEF.md
# Dictionary-Rebuilding Cache Line Decompressor

This block expands one compressed cache line back into its sixteen 32-bit words. The input is a single packed bit vector holding a run of variable-length code words. Each code word opens with a 2-bit or a 4-bit type prefix. The type says whether the word is zero, a zero-extended byte, a literal, or a full or partial copy of an entry in a small dictionary. The block reads one code word per clock and writes one decoded word into the output line.

The dictionary never travels with the data. The block rebuilds it while decoding. Every decoded word that is not one of the two fixed patterns (zero or a single low byte) is written into the next slot in first-in-first-out order, starting from an all-zero table at every start. The words are written in the same order as the encoder that made the stream, so a later reference to an index finds the same content the encoder saw.

A start strobe loads the stream. The decoded line and a done flag appear sixteen cycles later. A reserved prefix stops decoding early and raises an error flag.

Top module: `line_unpack`

## Requirements
- R1: After reset, `done_o` and `err_o` are low and `line_o` is all zero.
- R2: Prefix 00 decodes to the word 0x00000000, uses 2 stream bits and is not written into the dictionary.
- R3: Prefix 1101 is followed by 8 bits. It decodes to that byte zero-extended to 32 bits and is not written into the dictionary.
- R4: Prefix 01 is followed by 32 bits that form the decoded word unchanged. The word is written into the dictionary.
- R5: Prefix 10 is followed by a 4-bit index. It decodes to the whole dictionary entry at that index, and the result is written into the dictionary again.
- R6: Prefix 1110 is followed by a 4-bit index and then 8 bits. The word is the top three bytes of the indexed entry with the stream byte below them. Prefix 1100 is followed by a 4-bit index and then 16 bits. The word is the top two bytes of the entry with the stream half-word below them. Both results are written into the dictionary.
- R7: The dictionary is cleared to all-zero entries at each start. Written words fill slots 0, 1, 2, ... in decode order, wrapping after the last slot.
- R8: The stream is consumed from its most significant bit downward, and every field is sent MSB first. Word k of the line appears at `line_o[32k+31:32k]`.
- R9: One word is decoded per cycle. `done_o` rises 16 clock edges after the edge that samples `start_i`. It stays high, with `line_o` unchanged, until the next start. A start clears `done_o`, `err_o` and `line_o` at the next edge.
- R10: Prefix 1111 stops decoding and raises `err_o` and `done_o` together. Words decoded before it are kept, and the remaining words stay zero.
- R11: A line compressed by the matching encoder comes back bit-exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load `stream_i` and begin decoding |
| stream_i | input | 544 | Packed compressed line, first code word at the MSB |
| line_o | output | 512 | Decoded line, word 0 in the low bits |
| done_o | output | 1 | Decoding finished (held until the next start) |
| err_o | output | 1 | Reserved prefix met |

## Verification
The bench runs a behavioural encoder over several kinds of line:
- Random words mostly come out as literals and test literal transport and the write order.
- Lines rich in zeros and small bytes test the fixed patterns. They also show that these words leave the dictionary untouched.
- Lines built from a small pool of repeated words test full matches.
- Lines sharing upper bytes test the two partial-match forms, which can only succeed if the index and the byte splice are both right.

A hand-built stream sets the dictionary slot of each code against expected values worked out by hand. The reserved prefix is checked for its stop point, and an index to a never-written slot shows the clear at start.

// File: rtl/line_unpack_pkg.sv
`timescale 1ns/1ps
package line_unpack_pkg;

    localparam int WORD_W    = 32;
    localparam int PFX_SHORT = 2;
    localparam int PFX_LONG  = 4;
    // widest code word: short prefix plus a literal word
    localparam int WIN_W     = PFX_SHORT + WORD_W;
    localparam int LEN_W     = $clog2(WIN_W + 1);

    typedef enum logic [2:0] {
        K_ZERO,
        K_LIT,
        K_FULL,
        K_BYTE,
        K_HI3,
        K_HI2,
        K_BAD
    } kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } state_e;

    typedef struct packed {
        kind_e              kind;
        logic [LEN_W-1:0]   len;
        logic [WORD_W-1:0]  word;
        logic               ins;
    } dec_t;

    // The first two bits select a short code; 11 opens a long code.
    function automatic kind_e classify(input logic [PFX_LONG-1:0] top);
        kind_e k;
        unique case (top[3:2])
            2'b00:   k = K_ZERO;
            2'b01:   k = K_LIT;
            2'b10:   k = K_FULL;
            default: begin
                unique case (top[1:0])
                    2'b00:   k = K_HI2;
                    2'b01:   k = K_BYTE;
                    2'b10:   k = K_HI3;
                    default: k = K_BAD;
                endcase
            end
        endcase
        return k;
    endfunction

endpackage

// File: rtl/lu_code_decode.sv
`timescale 1ns/1ps
module lu_code_decode
    import line_unpack_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [WIN_W-1:0]  win_i,
    input  logic [WORD_W-1:0] entry_i,
    output logic [IDX_W-1:0]  rd_idx_o,
    output dec_t              dec_o
);

    localparam logic [LEN_W-1:0] LEN_ZERO = LEN_W'(PFX_SHORT);
    localparam logic [LEN_W-1:0] LEN_LIT  = LEN_W'(PFX_SHORT + WORD_W);
    localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(PFX_SHORT + IDX_W);
    localparam logic [LEN_W-1:0] LEN_BYTE = LEN_W'(PFX_LONG + 8);
    localparam logic [LEN_W-1:0] LEN_HI3  = LEN_W'(PFX_LONG + IDX_W + 8);
    localparam logic [LEN_W-1:0] LEN_HI2  = LEN_W'(PFX_LONG + IDX_W + 16);

    // field start positions inside the window
    localparam int AFT_S = WIN_W - PFX_SHORT - 1;
    localparam int AFT_L = WIN_W - PFX_LONG - 1;
    localparam int AFT_I = AFT_L - IDX_W;

    kind_e            kind;
    logic [IDX_W-1:0] idx_s;
    logic [IDX_W-1:0] idx_l;

    always_comb begin
        kind     = classify(win_i[WIN_W-1 -: PFX_LONG]);
        idx_s    = win_i[AFT_S -: IDX_W];
        idx_l    = win_i[AFT_L -: IDX_W];
        rd_idx_o = (kind == K_FULL) ? idx_s : idx_l;

        dec_o.kind = kind;
        dec_o.len  = '0;
        dec_o.word = '0;
        dec_o.ins  = 1'b0;
        unique case (kind)
            K_ZERO: begin
                dec_o.len = LEN_ZERO;
            end
            K_LIT: begin
                dec_o.len  = LEN_LIT;
                dec_o.word = win_i[AFT_S -: WORD_W];
                dec_o.ins  = 1'b1;
            end
            K_FULL: begin
                dec_o.len  = LEN_FULL;
                dec_o.word = entry_i;
                dec_o.ins  = 1'b1;
            end
            K_BYTE: begin
                dec_o.len  = LEN_BYTE;
                dec_o.word = {{(WORD_W-8){1'b0}}, win_i[AFT_L -: 8]};
            end
            K_HI3: begin
                dec_o.len  = LEN_HI3;
                dec_o.word = {entry_i[WORD_W-1:8], win_i[AFT_I -: 8]};
                dec_o.ins  = 1'b1;
            end
            K_HI2: begin
                dec_o.len  = LEN_HI2;
                dec_o.word = {entry_i[WORD_W-1:16], win_i[AFT_I -: 16]};
                dec_o.ins  = 1'b1;
            end
            default: begin
                dec_o.len = '0;
            end
        endcase
    end

endmodule

// File: rtl/lu_dict.sv
`timescale 1ns/1ps
module lu_dict
    import line_unpack_pkg::*;
#(
    parameter int DICT_N = 16,
    parameter int IDX_W  = $clog2(DICT_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              we_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic [IDX_W-1:0]  ptr_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DICT_N - 1);

    logic [WORD_W-1:0] slot_q [DICT_N];
    logic [IDX_W-1:0]  ptr_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            for (int i = 0; i < DICT_N; i++) begin
                slot_q[i] <= '0;
            end
            ptr_q <= '0;
        end else if (we_i) begin
            slot_q[ptr_q] <= wdata_i;
            ptr_q         <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    always_comb begin
        if (int'(rd_idx_i) < DICT_N) begin
            rd_data_o = slot_q[rd_idx_i];
        end else begin
            rd_data_o = '0;
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/line_unpack.sv
`timescale 1ns/1ps
module line_unpack
    import line_unpack_pkg::*;
#(
    parameter int N_WORDS = 16,
    parameter int DICT_N  = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start_i,
    input  logic [N_WORDS*WIN_W-1:0]    stream_i,
    output logic [N_WORDS*WORD_W-1:0]   line_o,
    output logic                        done_o,
    output logic                        err_o
);

    localparam int IDX_W    = $clog2(DICT_N);
    localparam int STREAM_W = N_WORDS * WIN_W;
    localparam int LINE_W   = N_WORDS * WORD_W;
    localparam int CNT_W    = $clog2(N_WORDS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(N_WORDS - 1);

    state_e              state_q;
    logic [STREAM_W-1:0] sr_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [WORD_W-1:0]   words_q [N_WORDS];
    logic                done_q;
    logic                err_q;

    logic                running;
    logic [WIN_W-1:0]    win;
    logic [IDX_W-1:0]    rd_idx;
    logic [WORD_W-1:0]   rd_entry;
    logic [IDX_W-1:0]    dict_ptr;
    dec_t                dec;

    assign running = (state_q == ST_RUN);
    assign win     = sr_q[STREAM_W-1 -: WIN_W];

    lu_code_decode #(
        .IDX_W (IDX_W)
    ) u_decode (
        .win_i    (win),
        .entry_i  (rd_entry),
        .rd_idx_o (rd_idx),
        .dec_o    (dec)
    );

    lu_dict #(
        .DICT_N (DICT_N),
        .IDX_W  (IDX_W)
    ) u_dict (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (start_i),
        .we_i      (running && dec.ins),
        .wdata_i   (dec.word),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_entry),
        .ptr_o     (dict_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sr_q    <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            for (int i = 0; i < N_WORDS; i++) begin
                words_q[i] <= '0;
            end
        end else if (start_i) begin
            state_q <= ST_RUN;
            sr_q    <= stream_i;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            for (int i = 0; i < N_WORDS; i++) begin
                words_q[i] <= '0;
            end
        end else if (running) begin
            if (dec.kind == K_BAD) begin
                err_q   <= 1'b1;
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
            end else begin
                words_q[cnt_q] <= dec.word;
                sr_q           <= sr_q << dec.len;
                if (cnt_q == CNT_LAST) begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < N_WORDS; g++) begin : g_line
        assign line_o[g*WORD_W +: WORD_W] = words_q[g];
    end

    assign done_o = done_q;
    assign err_o  = err_q;

endmodule

// File: rtl/line_unpack_chk.sv
`timescale 1ns/1ps
module line_unpack_chk #(
    parameter int N_WORDS = 16,
    parameter int IDX_W   = 4,
    parameter int CNT_W   = 4,
    parameter int LINE_W  = 512
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              done_o,
    input logic              err_o,
    input logic [LINE_W-1:0] line_o,
    input logic              running,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [IDX_W-1:0]  dict_ptr
);

    // R10: an error always ends the line
    assert_err_ends_R10: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);

    // R9: a start clears the flags and the line
    assert_start_clears_R9: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!done_o && !err_o && line_o == '0));

    // R9: done holds until the next start
    assert_done_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o);

    // R9: normal completion only after the last word slot
    assert_done_timing_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(done_o) && !err_o) |-> ($past(cnt_q) == CNT_W'(N_WORDS - 1)));

    // R8: line stays put while idle
    assert_line_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (!running && !start_i) |=> $stable(line_o));

    // R7: writes never outrun decoded words
    assert_ptr_bound_R7: assert property (@(posedge clk) disable iff (rst)
        running |-> (int'(dict_ptr) <= int'(cnt_q)));

endmodule

bind line_unpack line_unpack_chk #(
    .N_WORDS (N_WORDS),
    .IDX_W   (IDX_W),
    .CNT_W   (CNT_W),
    .LINE_W  (LINE_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .done_o   (done_o),
    .err_o    (err_o),
    .line_o   (line_o),
    .running  (running),
    .cnt_q    (cnt_q),
    .dict_ptr (dict_ptr)
);

// File: tb/line_unpack_bench.sv
`timescale 1ns/1ps
module line_unpack_bench;

    localparam int NW       = 16;
    localparam int STREAM_W = NW * 34;
    localparam int LINE_W   = NW * 32;
    localparam int NVEC     = 8;

    // stimulus table: line kind, seed, expected decode cycles
    localparam int          VKIND [NVEC] = '{0, 1, 2, 3, 4, 4, 0, 3};
    localparam logic [31:0] VSEED [NVEC] = '{32'h1234_5678, 32'h0bad_f00d, 32'h7777_1111,
                                             32'h2468_ace0, 32'h1357_9bdf, 32'hface_b00c,
                                             32'h0000_0001, 32'h8000_0003};
    localparam int          VCYC  [NVEC] = '{16, 16, 16, 16, 16, 16, 16, 16};

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                start_i = 1'b0;
    logic [STREAM_W-1:0] stream_i = '0;
    logic [LINE_W-1:0]   line_o;
    logic                done_o;
    logic                err_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [31:0]         src [NW];
    logic [LINE_W-1:0]   exp_line;
    logic [STREAM_W-1:0] cs;
    int                  cpos;
    logic [31:0]         rs;
    int                  cyc;

    always #2.5 clk = ~clk;

    line_unpack u_line_unpack (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .stream_i (stream_i),
        .line_o   (line_o),
        .done_o   (done_o),
        .err_o    (err_o)
    );

    task automatic chk(input string tag, input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    task automatic emit(input logic [33:0] v, input int n);
        for (int b = n - 1; b >= 0; b--) begin
            cpos--;
            cs[cpos] = v[b];
        end
    endtask

    task automatic new_stream();
        cs   = '0;
        cpos = STREAM_W;
    endtask

    // behavioural encoder with a first-in-first-out dictionary
    task automatic compress();
        logic [31:0] d [16];
        int dn;
        int dp;
        int hit;
        new_stream();
        dn = 0;
        dp = 0;
        for (int i = 0; i < 16; i++) d[i] = '0;
        for (int k = 0; k < NW; k++) begin
            logic [31:0] w;
            w = src[k];
            if (w == 0) begin
                emit(2'b00, 2);
            end else if (w[31:8] == 0) begin
                emit(4'b1101, 4);
                emit({26'd0, w[7:0]}, 8);
            end else begin
                hit = -1;
                for (int i = 0; i < dn; i++) if (hit < 0 && d[i] == w) hit = i;
                if (hit >= 0) begin
                    emit(2'b10, 2);
                    emit(34'(hit), 4);
                end else begin
                    for (int i = 0; i < dn; i++) if (hit < 0 && d[i][31:8] == w[31:8]) hit = i;
                    if (hit >= 0) begin
                        emit(4'b1110, 4);
                        emit(34'(hit), 4);
                        emit({26'd0, w[7:0]}, 8);
                    end else begin
                        for (int i = 0; i < dn; i++) if (hit < 0 && d[i][31:16] == w[31:16]) hit = i;
                        if (hit >= 0) begin
                            emit(4'b1100, 4);
                            emit(34'(hit), 4);
                            emit({18'd0, w[15:0]}, 16);
                        end else begin
                            emit(2'b01, 2);
                            emit({2'b00, w}, 32);
                        end
                    end
                end
                d[dp] = w;
                dp = (dp + 1) % 16;
                if (dn < 16) dn++;
            end
        end
    endtask

    task automatic gen_line(input int kind, input logic [31:0] seed);
        logic [31:0] pool [3];
        logic [31:0] base;
        rs = seed;
        for (int i = 0; i < 3; i++) pool[i] = rnd() | 32'h0100_0000;
        base = pool[0];
        for (int i = 0; i < NW; i++) begin
            logic [31:0] r;
            int sel;
            r = rnd();
            sel = (kind == 4) ? int'(rnd() % 6) : 0;
            case (kind)
                0: src[i] = r;
                1: src[i] = (i % 3 == 0) ? 32'h0 : (i % 3 == 1) ? {24'h0, r[7:0]} : r;
                2: src[i] = pool[r % 3];
                3: src[i] = (i % 3 == 0) ? base : (i % 3 == 1) ? {base[31:8], r[7:0]}
                                                               : {base[31:16], r[15:0]};
                default: begin
                    case (sel)
                        0: src[i] = 32'h0;
                        1: src[i] = {24'h0, r[7:0]};
                        2: src[i] = pool[r % 3];
                        3: src[i] = {base[31:8], r[7:0]};
                        4: src[i] = {base[31:16], r[15:0]};
                        default: src[i] = r;
                    endcase
                end
            endcase
        end
        for (int i = 0; i < NW; i++) exp_line[i*32 +: 32] = src[i];
    endtask

    task automatic run_dec(input logic [STREAM_W-1:0] s);
        @(negedge clk);
        stream_i = s;
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (!done_o && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 line", line_o, '0);
        chk("R1 done", LINE_W'(done_o), '0);
        chk("R1 err", LINE_W'(err_o), '0);
        @(negedge clk);
        rst = 1'b0;

        // R11 / R8 / R9: round trip over the stimulus table
        for (int v = 0; v < NVEC; v++) begin
            gen_line(VKIND[v], VSEED[v]);
            compress();
            run_dec(cs);
            chk($sformatf("R11 row %0d line", v), line_o, exp_line);
            chk($sformatf("R9 row %0d cycles", v), LINE_W'(cyc), LINE_W'(VCYC[v]));
            chk($sformatf("R11 row %0d err", v), LINE_W'(err_o), '0);
        end

        // R3 R4 R5 R6 R7 R2: hand-built stream
        new_stream();
        emit(4'b1101, 4); emit(34'h5a, 8);          // w0 = 0000005a, no write
        emit(2'b01, 2);   emit(34'h1122_3344, 32);  // w1 -> slot 0
        emit(2'b01, 2);   emit(34'h5566_7788, 32);  // w2 -> slot 1
        emit(2'b10, 2);   emit(34'd1, 4);           // w3 -> slot 2
        emit(4'b1110, 4); emit(34'd0, 4); emit(34'h99, 8);    // w4 -> slot 3
        emit(4'b1100, 4); emit(34'd3, 4); emit(34'habcd, 16); // w5 -> slot 4
        emit(2'b10, 2);   emit(34'd2, 4);           // w6 -> slot 5
        emit(2'b10, 2);   emit(34'd4, 4);           // w7 -> slot 6
        emit(2'b00, 2);                             // w8 no write
        emit(2'b01, 2);   emit(34'hcafe_f00d, 32);  // w9 -> slot 7
        emit(2'b10, 2);   emit(34'd7, 4);           // w10
        emit(2'b10, 2);   emit(34'd12, 4);          // w11 never written
        run_dec(cs);
        chk("R3 byte word", LINE_W'(line_o[0*32 +: 32]), LINE_W'(32'h0000_005a));
        chk("R4 literal word", LINE_W'(line_o[1*32 +: 32]), LINE_W'(32'h1122_3344));
        chk("R5 full match", LINE_W'(line_o[3*32 +: 32]), LINE_W'(32'h5566_7788));
        chk("R6 three-byte match", LINE_W'(line_o[4*32 +: 32]), LINE_W'(32'h1122_3399));
        chk("R6 two-byte match", LINE_W'(line_o[5*32 +: 32]), LINE_W'(32'h1122_abcd));
        chk("R7 match writes slot", LINE_W'(line_o[6*32 +: 32]), LINE_W'(32'h5566_7788));
        chk("R7 partial writes slot", LINE_W'(line_o[7*32 +: 32]), LINE_W'(32'h1122_abcd));
        chk("R2 zero word", LINE_W'(line_o[8*32 +: 32]), '0);
        chk("R2 zero not written", LINE_W'(line_o[10*32 +: 32]), LINE_W'(32'hcafe_f00d));
        chk("R7 cleared slot", LINE_W'(line_o[11*32 +: 32]), '0);
        chk("R8 tail zeros", LINE_W'(line_o[LINE_W-1 -: 128]), '0);

        // R10: reserved prefix at word 2
        new_stream();
        emit(2'b01, 2); emit(34'h0102_0304, 32);
        emit(2'b00, 2);
        emit(4'b1111, 4);
        emit(2'b01, 2); emit(34'hffff_ffff, 32);
        run_dec(cs);
        chk("R10 err", LINE_W'(err_o), LINE_W'(1));
        chk("R10 stop cycle", LINE_W'(cyc), LINE_W'(3));
        chk("R10 kept words", line_o, LINE_W'(32'h0102_0304));

        // R9 / R2: start clears error, all-zero stream, done held
        run_dec('0);
        chk("R9 err cleared", LINE_W'(err_o), '0);
        chk("R2 all zero line", line_o, '0);
        chk("R9 zero stream cycles", LINE_W'(cyc), LINE_W'(16));
        gen_line(0, 32'h0505_5050);
        compress();
        run_dec(cs);
        repeat (5) @(negedge clk);
        chk("R9 done held", LINE_W'(done_o), LINE_W'(1));
        chk("R9 line held", line_o, exp_line);

        finish_up();
    end

endmodule